// File: doc/BRIEF.md
# Segmented Carry-Truncated Approximate Adder

This block adds two unsigned operands with a carry chain that is deliberately cut. The low-order part of the word is split into equal-width segments. Each segment is a small ripple-carry adder whose carry-in is tied to 0, and its carry-out is thrown away. All segments therefore settle at the same time. The bits above the segmented region form one exact ripple-carry adder, which also starts from a carry-in of 0. Its carry-out becomes the block's carry-out.

The number of approximate segments is a parameter. It trades precision for the length of the longest carry path. With zero approximate segments the block is a plain exact adder. When every segment is approximate, the longest path is one segment wide. An error appears only when a real carry would have crossed a cut. The result is then too small by exactly the weight of each dropped carry.

The block is purely combinational and has no clock or reset. It is meant to sit inside datapaths such as filter accumulators that can tolerate a bounded, data-dependent shortfall.

Top module: `sca_adder`

## Requirements
- R1: With APPROX_SEGS = 0, {cout, sum} equals opa + opb exactly for every operand pair.
- R2: For approximate segment k (bits k*SEG_W up to k*SEG_W+SEG_W-1, for k below APPROX_SEGS), the sum bits equal the low SEG_W bits of the two operand slices added with carry-in 0. They do not depend on any operand bit below that segment.
- R3: When WIDTH exceeds APPROX_SEGS*SEG_W, the bits from APPROX_SEGS*SEG_W upward together with cout equal the full sum of the two upper operand slices, with carry-in 0.
- R4: When APPROX_SEGS*SEG_W equals WIDTH, cout is the carry-out of the topmost segment, computed from that segment's slices alone.
- R5: {cout, sum} equals opa + opb minus the sum of c_k * 2^((k+1)*SEG_W), taken over every approximate segment k whose upper edge lies below WIDTH. Here c_k is the carry out of that segment's own slice addition.
- R6: The output equals the exact sum exactly when none of those segment carries is set. Otherwise it is strictly smaller.
- R7: A carry produced by an approximate segment never changes any output bit above it. For example, with defaults, 16'h000F + 16'h0001 gives sum 16'h0000 and cout 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| opa | input | WIDTH | First unsigned operand |
| opb | input | WIDTH | Second unsigned operand |
| sum | output | WIDTH | Approximate sum |
| cout | output | 1 | Carry-out of the exact upper part, or of the top segment when all segments are approximate |

## Verification
Every result is combinational, so sum and cout are due in the same cycle the operands change, with no register on the path. The bench changes operands on the falling clock edge and samples a quarter period later, well before the next rising edge. Expected values come from two independent models. One is a bit-serial adder that clears its carry at every cut. The other is the exact sum minus the weighted segment carries. Both are checked across three parameter sets: no approximation, partial approximation and full approximation.

// File: rtl/sca_pkg.sv
package sca_pkg;

  // one-bit full-adder sum
  function automatic logic fa_sum(input logic a, input logic b, input logic c);
    return a ^ b ^ c;
  endfunction

  // one-bit full-adder carry (majority)
  function automatic logic fa_carry(input logic a, input logic b, input logic c);
    return (a & b) | (a & c) | (b & c);
  endfunction

  // width of the exact upper region
  function automatic int unsigned exact_width(input int unsigned total,
                                              input int unsigned seg_w,
                                              input int unsigned nseg);
    return total - seg_w * nseg;
  endfunction

endpackage

// File: rtl/sca_ripple.sv
module sca_ripple #(
  parameter int unsigned W = 4
) (
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  input  logic         cin,
  output logic [W-1:0] s,
  output logic         co
);
  logic [W:0] chain;

  assign chain[0] = cin;

  for (genvar i = 0; i < W; i++) begin : g_bit
    assign s[i]       = sca_pkg::fa_sum(a[i], b[i], chain[i]);
    assign chain[i+1] = sca_pkg::fa_carry(a[i], b[i], chain[i]);
  end

  assign co = chain[W];
endmodule

// File: rtl/sca_approx_bank.sv
module sca_approx_bank #(
  parameter int unsigned SEG_W = 4,
  parameter int unsigned NSEG  = 2
) (
  input  logic [SEG_W*NSEG-1:0] a,
  input  logic [SEG_W*NSEG-1:0] b,
  output logic [SEG_W*NSEG-1:0] s,
  output logic [NSEG-1:0]       seg_co
);
  // every segment starts from a tied-off carry of 0, so all run in parallel
  for (genvar k = 0; k < NSEG; k++) begin : g_seg
    sca_ripple #(.W(SEG_W)) u_seg (
      .a   (a[k*SEG_W +: SEG_W]),
      .b   (b[k*SEG_W +: SEG_W]),
      .cin (1'b0),
      .s   (s[k*SEG_W +: SEG_W]),
      .co  (seg_co[k])
    );
  end
endmodule

// File: rtl/sca_adder.sv
module sca_adder #(
  parameter int unsigned WIDTH       = 16,
  parameter int unsigned SEG_W       = 4,
  parameter int unsigned APPROX_SEGS = 2
) (
  input  logic [WIDTH-1:0] opa,
  input  logic [WIDTH-1:0] opb,
  output logic [WIDTH-1:0] sum,
  output logic             cout
);
  localparam int unsigned LO_W = SEG_W * APPROX_SEGS;
  localparam int unsigned HI_W = sca_pkg::exact_width(WIDTH, SEG_W, APPROX_SEGS);
  localparam int unsigned CV_W = (APPROX_SEGS > 0) ? APPROX_SEGS : 1;

  // raw carry of every approximate segment, and the subset that is discarded
  logic [CV_W-1:0] seg_cout;
  logic [CV_W-1:0] drop_carry;

  if (APPROX_SEGS > 0) begin : g_lo
    logic [LO_W-1:0] lo_sum;
    logic [APPROX_SEGS-1:0] lo_co;
    sca_approx_bank #(.SEG_W(SEG_W), .NSEG(APPROX_SEGS)) u_bank (
      .a      (opa[LO_W-1:0]),
      .b      (opb[LO_W-1:0]),
      .s      (lo_sum),
      .seg_co (lo_co)
    );
    assign sum[LO_W-1:0] = lo_sum;
    assign seg_cout      = lo_co;
  end else begin : g_no_lo
    assign seg_cout = '0;
  end

  if (HI_W > 0) begin : g_hi
    logic [HI_W-1:0] hi_sum;
    logic            hi_co;
    // exact upper part: its carry-in is cut from the segmented region
    sca_ripple #(.W(HI_W)) u_exact (
      .a   (opa[WIDTH-1:LO_W]),
      .b   (opb[WIDTH-1:LO_W]),
      .cin (1'b0),
      .s   (hi_sum),
      .co  (hi_co)
    );
    assign sum[WIDTH-1:LO_W] = hi_sum;
    assign cout              = hi_co;
    assign drop_carry        = seg_cout;
  end else begin : g_all_approx
    // top segment carry is the block carry-out, not a dropped one
    assign cout = seg_cout[CV_W-1];
    always_comb begin
      drop_carry         = seg_cout;
      drop_carry[CV_W-1] = 1'b0;
    end
  end
endmodule

// File: rtl/sca_adder_chk.sv
module sca_adder_chk #(
  parameter int unsigned WIDTH       = 16,
  parameter int unsigned SEG_W       = 4,
  parameter int unsigned APPROX_SEGS = 2
) (
  input logic [WIDTH-1:0] opa,
  input logic [WIDTH-1:0] opb,
  input logic [WIDTH-1:0] sum,
  input logic             cout,
  input logic [((APPROX_SEGS > 0) ? APPROX_SEGS : 1)-1:0] seg_cout,
  input logic [((APPROX_SEGS > 0) ? APPROX_SEGS : 1)-1:0] drop_carry
);
  localparam int unsigned LO_W = SEG_W * APPROX_SEGS;
  localparam int unsigned HI_W = WIDTH - LO_W;

  logic [WIDTH:0] exact_v, got_v, penalty_v;

  always_comb begin
    exact_v   = {1'b0, opa} + {1'b0, opb};
    got_v     = {cout, sum};
    penalty_v = '0;
    for (int k = 0; k < int'(APPROX_SEGS); k++) begin
      if (drop_carry[k]) penalty_v = penalty_v + ((WIDTH+1)'(1) << ((k + 1) * SEG_W));
    end
    AST_DROP_ACCOUNTS: assert (got_v + penalty_v == exact_v)
      else $error("output does not match exact sum minus dropped carries"); // R5
    if (drop_carry == '0) begin
      AST_NO_DROP_EXACT: assert (got_v == exact_v)
        else $error("no carry dropped but result inexact"); // R6
    end else begin
      AST_DROP_SHORT: assert (got_v < exact_v)
        else $error("carry dropped but result not short"); // R6
    end
  end

  for (genvar k = 0; k < APPROX_SEGS; k++) begin : g_seg_chk
    logic [SEG_W:0] local_v;
    always_comb begin
      local_v = {1'b0, opa[k*SEG_W +: SEG_W]} + {1'b0, opb[k*SEG_W +: SEG_W]};
      AST_SEG_LOCAL: assert (sum[k*SEG_W +: SEG_W] == local_v[SEG_W-1:0])
        else $error("segment sum depends on lower bits"); // R2
      AST_SEG_CARRY: assert (seg_cout[k] == local_v[SEG_W])
        else $error("segment carry wrong"); // R7
    end
  end

  if (HI_W > 0) begin : g_hi_chk
    logic [HI_W:0] hi_v;
    always_comb begin
      hi_v = {1'b0, opa[WIDTH-1:LO_W]} + {1'b0, opb[WIDTH-1:LO_W]};
      AST_HI_EXACT: assert ({cout, sum[WIDTH-1:LO_W]} == hi_v)
        else $error("exact upper part wrong"); // R3
    end
  end else begin : g_top_chk
    always_comb begin
      AST_TOP_SEG_CARRY: assert (cout == seg_cout[APPROX_SEGS-1])
        else $error("carry-out not from top segment"); // R4
    end
  end

  if (APPROX_SEGS == 0) begin : g_exact_chk
    always_comb begin
      AST_EXACT_CFG: assert (got_v == exact_v)
        else $error("exact configuration inexact"); // R1
    end
  end
endmodule

bind sca_adder sca_adder_chk #(
  .WIDTH(WIDTH), .SEG_W(SEG_W), .APPROX_SEGS(APPROX_SEGS)
) u_chk (
  .opa(opa), .opb(opb), .sum(sum), .cout(cout),
  .seg_cout(seg_cout), .drop_carry(drop_carry)
);

// File: tb/tb_sca_adder.sv
module tb_sca_adder;
  localparam int CLK_PERIOD = 10;
  localparam int W = 16;
  localparam int S = 4;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  logic [W-1:0] a, b;
  logic [W-1:0] sum_p, sum_e, sum_f;
  logic         co_p, co_e, co_f;

  int n_tests = 0;
  int n_fail  = 0;
  bit done    = 1'b0;

  sca_adder #(.WIDTH(W), .SEG_W(S), .APPROX_SEGS(2)) dut (
    .opa(a), .opb(b), .sum(sum_p), .cout(co_p));
  sca_adder #(.WIDTH(W), .SEG_W(S), .APPROX_SEGS(0)) dut_exact (
    .opa(a), .opb(b), .sum(sum_e), .cout(co_e));
  sca_adder #(.WIDTH(W), .SEG_W(S), .APPROX_SEGS(4)) dut_full (
    .opa(a), .opb(b), .sum(sum_f), .cout(co_f));

  // bit-serial model: carry is cleared on entry to each cut boundary
  function automatic logic [W:0] ref_serial(input logic [W-1:0] x, input logic [W-1:0] y,
                                            input int nseg);
    logic c = 1'b0;
    logic [W:0] r = '0;
    for (int i = 0; i < W; i++) begin
      if (i % S == 0 && i / S >= 1 && i / S <= nseg) c = 1'b0;
      r[i] = x[i] ^ y[i] ^ c;
      c    = (x[i] & y[i]) | (c & (x[i] ^ y[i]));
    end
    r[W] = c;
    return r;
  endfunction

  // exact sum minus weighted carries of the cut segments
  function automatic logic [W:0] ref_penalty(input logic [W-1:0] x, input logic [W-1:0] y,
                                             input int nseg);
    logic [W:0] acc = {1'b0, x} + {1'b0, y};
    for (int k = 0; k < nseg; k++) begin
      int unsigned seg_sum = int'(x[k*S +: S]) + int'(y[k*S +: S]);
      if ((k + 1) * S < W && seg_sum >= (1 << S))
        acc = acc - ((W+1)'(1) << ((k + 1) * S));
    end
    return acc;
  endfunction

  task automatic check(input string req, input logic [W:0] got, input logic [W:0] exp);
    n_tests++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s: got %h expected %h (a=%h b=%h)", req, got, exp, a, b);
    end
  endtask

  task automatic drive(input logic [W-1:0] x, input logic [W-1:0] y);
    @(negedge clk);
    a = x;
    b = y;
    #(CLK_PERIOD/4);
  endtask

  task automatic t_reset;
    drive('0, '0);
    check("R1 zero exact", {co_e, sum_e}, '0);
    check("R2 zero partial", {co_p, sum_p}, '0);
    check("R4 zero full", {co_f, sum_f}, '0);
  endtask

  task automatic t_exact_cfg;
    drive(16'hFFFF, 16'hFFFF);
    check("R1 all ones", {co_e, sum_e}, 17'h1FFFE);
    drive(16'h0FFF, 16'h0001);
    check("R1 long ripple", {co_e, sum_e}, 17'h01000);
  endtask

  task automatic t_segment_local;
    drive(16'h000F, 16'h0001);
    check("R7 seg0 carry dropped", {co_p, sum_p}, 17'h00000);
    drive(16'h123F, 16'h4561);
    check("R2 seg0 independent of upper", {13'h0, sum_p[3:0]}, 17'h0);
    drive(16'h00F7, 16'h0019);
    check("R2 seg1 ignores seg0 carry", {13'h0, sum_p[7:4]}, 17'h0);
  endtask

  task automatic t_boundary;
    drive(16'h00F0, 16'h0010);
    check("R5 carry at exact boundary", {co_p, sum_p}, 17'h00000);
    drive(16'hAAAA, 16'hAAAA);
    check("R5 alternating doubled", {co_p, sum_p}, 17'h15444);
    drive(16'hFFFF, 16'hFFFF);
    check("R5 all ones", {co_p, sum_p}, 17'h1FEEE);
    drive(16'hAAAA, 16'h5555);
    check("R6 no carry exact", {co_p, sum_p}, 17'h0FFFF);
  endtask

  task automatic t_hi_exact;
    drive(16'hF000, 16'h1000);
    check("R3 upper carry out", {co_p, sum_p}, 17'h10000);
    drive(16'h0F00, 16'h0100);
    check("R3 upper internal ripple", {co_p, sum_p}, 17'h01000);
  endtask

  task automatic t_full_approx;
    drive(16'hFFFF, 16'h0001);
    check("R4 full seg0 drop", {co_f, sum_f}, 17'h0FFF0);
    drive(16'hF000, 16'h1000);
    check("R4 top seg carry kept", {co_f, sum_f}, 17'h10000);
    drive(16'h0F00, 16'h0100);
    check("R4 seg2 carry dropped", {co_f, sum_f}, 17'h00000);
  endtask

  task automatic t_random;
    for (int i = 0; i < 300; i++) begin
      logic [W:0] ex;
      drive(W'($urandom), W'($urandom));
      ex = {1'b0, a} + {1'b0, b};
      check("R1 random", {co_e, sum_e}, ex);
      check("R5 random partial serial", {co_p, sum_p}, ref_serial(a, b, 2));
      check("R5 random partial penalty", {co_p, sum_p}, ref_penalty(a, b, 2));
      check("R4 random full", {co_f, sum_f}, ref_serial(a, b, 4));
      if (ref_penalty(a, b, 2) == ex)
        check("R6 random exact when no drop", {co_p, sum_p}, ex);
    end
  endtask

  initial begin
    a = '0;
    b = '0;
    void'($urandom(32'h5EED));
    repeat (3) @(posedge clk);
    rst_n = 1'b1;
    t_reset();
    t_exact_cfg();
    t_segment_local();
    t_boundary();
    t_hi_exact();
    t_full_approx();
    t_random();
    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 100000);
    if (!done) begin
      n_tests++;
      n_fail++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end
endmodule